// File: doc/BRIEF.md
# Composite Video Sync Timing Generator

This block produces the line and field timing for an NTSC- or PAL-style composite encoder. It advances one pixel position on each cycle where the pixel-rate enable is high. From that count it derives registered horizontal and vertical sync, blanking, a colour-burst gate window and a half-rate pixel clock. The rest of the encoder uses these signals to place sync tips, blank the picture and insert burst.

The same set of counters serves two roles. As sync master it drives the sync outputs. As sync slave it follows sync pulses from outside: the horizontal counter clears on an incoming horizontal sync fall, and the half-line counter clears on an incoming vertical sync fall. Between pulses the counters free-run, so they keep their place if a pulse is missing.

Vertical position is counted in half-lines. An interlaced field is exactly half a frame. In non-interlaced operation a select trims each field by half a line, either shorter or longer, so every field begins at a line start.

Top module: `vid_sync_gen`

## Requirements
- R1: With `sel_pal` low, or with `sel_pal` and `sel_pal60` both high, a line lasts `CLK_LINE_525` enabled cycles and a frame has `LINES_525` lines. With `sel_pal` high and `sel_pal60` low, the values are `CLK_LINE_625` and `LINES_625`. `h_count` steps 0 to length-1 on each enabled cycle and then wraps to 0.
- R2: `half_line` advances when `h_count` becomes 0 and when it becomes half the line length. A field lasts N half-lines when `sel_interlace` is high, where N is the frame line count. When `sel_interlace` is low it lasts N-1 half-lines if `sel_long_field` is low and N+1 if it is high. `field` toggles at each field wrap when interlaced and stays 0 otherwise.
- R3: `hsync_out_n` is low exactly while `h_count` < `HSYNC_W`. `vsync_out_n` is low exactly while `half_line` < `VSYNC_HL`. `sync_oe` follows `sel_master` one cycle later (1 = the block drives sync).
- R4: `blank` is high while `h_count` < `ACTIVE_START`, or `h_count` >= line length − `FRONT_PORCH`, or `half_line` < `VBLANK_HL`.
- R5: `burst_gate` is high while `h_count` lies in [`HSYNC_W`+`BURST_DELAY`, `HSYNC_W`+`BURST_DELAY`+`BURST_LEN`) and `half_line` >= `VSYNC_HL`.
- R6: `pix_clk` is 1 whenever `h_count` is 0 and inverts on every other enabled cycle, so it runs at half the enable rate and is realigned at each line start.
- R7: In slave mode (`sel_master` low), an enabled cycle that sees `hsync_in_n` low, after it was high on the previous enabled cycle, sets `h_count` to 0.
- R8: In slave mode, an enabled cycle that sees a `vsync_in_n` fall sets `half_line` to 0. `field` becomes 0 if that cycle is also a line start and 1 otherwise.
- R9: A cycle with `pix_en` low leaves `h_count`, `half_line`, `field` and `pix_clk` unchanged.
- R10: Synchronous active-high `rst` gives `h_count`=0, `half_line`=0, `field`=0, `hsync_out_n`=0, `vsync_out_n`=0, `blank`=1, `burst_gate`=0, `pix_clk`=1, `sync_oe`=0 and `pal_colour`=0.
- R11: `pal_colour` follows `sel_pal` one cycle later, independently of `sel_pal60`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-rate enable; counters advance when high |
| sel_pal | input | 1 | 0 = 525-line standard, 1 = 625-line standard |
| sel_pal60 | input | 1 | With `sel_pal` high, selects 525-line timing |
| sel_master | input | 1 | 1 = drive sync, 0 = follow external sync |
| sel_interlace | input | 1 | 1 = interlaced fields |
| sel_long_field | input | 1 | Non-interlaced trim: 0 = half line short, 1 = half line long |
| hsync_in_n | input | 1 | External horizontal sync, active low |
| vsync_in_n | input | 1 | External vertical sync, active low |
| hsync_out_n | output | 1 | Generated horizontal sync, active low |
| vsync_out_n | output | 1 | Generated vertical sync, active low |
| sync_oe | output | 1 | Drive enable for the sync pins |
| pix_clk | output | 1 | Half-rate pixel clock |
| blank | output | 1 | Blanking interval |
| burst_gate | output | 1 | Colour-burst window |
| pal_colour | output | 1 | PAL colour encoding in use |
| field | output | 1 | Field parity |
| h_count | output | HW | Pixel position in line |
| half_line | output | VW | Half-line position in field |

## Verification
The assertions assume that the standard and master selects stay constant while the block is out of reset. They also assume the timing parameters place the burst window inside horizontal blanking, and that an external sync pulse stays low for at least one enabled cycle. The bench changes selects only while reset is held and uses a small parameter set that satisfies the window ordering. Its slave pulses stay low for two cycles, with the pulse spacing shorter than the line, so each fall is seen as an edge.

// File: rtl/vs_pkg.sv
package vs_pkg;

  typedef enum logic [1:0] {
    SCAN_SHORT = 2'd0,
    SCAN_INTER = 2'd1,
    SCAN_LONG  = 2'd2
  } scan_e;

  // Field length in half-lines for a frame of 'lines' lines.
  function automatic int field_half_lines(input int lines, input scan_e scan);
    case (scan)
      SCAN_SHORT: return lines - 1;
      SCAN_LONG:  return lines + 1;
      default:    return lines;
    endcase
  endfunction

endpackage

// File: rtl/vs_line_timer.sv
module vs_line_timer #(
  parameter int HW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          slave,
  input  logic          hsync_in_n,
  input  logic [HW-1:0] line_len,
  output logic [HW-1:0] h_cur,
  output logic [HW-1:0] h_nxt,
  output logic          line_start,
  output logic          mid_line,
  output logic          pix_clk
);

  logic          hs_prev;
  logic          hs_fall;
  logic [HW-1:0] last_px;
  logic [HW-1:0] half_px;

  assign last_px = line_len - HW'(1);
  assign half_px = line_len >> 1;

  always_comb begin
    hs_fall = pix_en & slave & hs_prev & ~hsync_in_n;
    h_nxt   = h_cur;
    if (pix_en) begin
      if (hs_fall || (h_cur >= last_px)) h_nxt = '0;
      else                               h_nxt = h_cur + HW'(1);
    end
    line_start = pix_en & (h_nxt == '0);
    mid_line   = pix_en & (h_nxt == half_px);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cur   <= '0;
      hs_prev <= 1'b1;
      pix_clk <= 1'b1;
    end else begin
      h_cur <= h_nxt;
      if (pix_en) begin
        hs_prev <= hsync_in_n;
        pix_clk <= line_start ? 1'b1 : ~pix_clk;
      end
    end
  end

endmodule

// File: rtl/vs_field_timer.sv
module vs_field_timer #(
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          slave,
  input  logic          vsync_in_n,
  input  logic          line_start,
  input  logic          mid_line,
  input  logic          interlace,
  input  logic [VW-1:0] field_len,
  output logic [VW-1:0] vh_cur,
  output logic [VW-1:0] vh_nxt,
  output logic          field
);

  logic vs_prev;
  logic vs_fall;
  logic step;
  logic wrap;
  logic field_nxt;

  always_comb begin
    vs_fall   = pix_en & slave & vs_prev & ~vsync_in_n;
    step      = line_start | mid_line;
    wrap      = step & (vh_cur >= field_len - VW'(1));
    vh_nxt    = vh_cur;
    field_nxt = field;
    if (vs_fall) begin
      vh_nxt    = '0;
      field_nxt = ~line_start;
    end else if (wrap) begin
      vh_nxt    = '0;
      field_nxt = interlace ? ~field : 1'b0;
    end else if (step) begin
      vh_nxt    = vh_cur + VW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vh_cur  <= '0;
      field   <= 1'b0;
      vs_prev <= 1'b1;
    end else begin
      vh_cur <= vh_nxt;
      field  <= field_nxt;
      if (pix_en) vs_prev <= vsync_in_n;
    end
  end

endmodule

// File: rtl/vs_decode.sv
module vs_decode #(
  parameter int HW           = 10,
  parameter int VW           = 10,
  parameter int HSYNC_W      = 64,
  parameter int ACTIVE_START = 122,
  parameter int FRONT_PORCH  = 16,
  parameter int BURST_DELAY  = 8,
  parameter int BURST_LEN    = 34,
  parameter int VSYNC_HL     = 6,
  parameter int VBLANK_HL    = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_nxt,
  input  logic [VW-1:0] vh_nxt,
  input  logic [HW-1:0] line_len,
  input  logic          sel_master,
  input  logic          sel_pal,
  output logic          hsync_out_n,
  output logic          vsync_out_n,
  output logic          blank,
  output logic          burst_gate,
  output logic          sync_oe,
  output logic          pal_colour
);

  localparam logic [HW-1:0] HS_END  = HW'(HSYNC_W);
  localparam logic [HW-1:0] ACT_BEG = HW'(ACTIVE_START);
  localparam logic [HW-1:0] FP_LEN  = HW'(FRONT_PORCH);
  localparam logic [HW-1:0] BG_BEG  = HW'(HSYNC_W + BURST_DELAY);
  localparam logic [HW-1:0] BG_END  = HW'(HSYNC_W + BURST_DELAY + BURST_LEN);
  localparam logic [VW-1:0] VS_END  = VW'(VSYNC_HL);
  localparam logic [VW-1:0] VB_END  = VW'(VBLANK_HL);

  logic hs_d, vs_d, bl_d, bg_d;

  always_comb begin
    hs_d = (h_nxt < HS_END);
    vs_d = (vh_nxt < VS_END);
    bl_d = (h_nxt < ACT_BEG) || (h_nxt >= (line_len - FP_LEN)) || (vh_nxt < VB_END);
    bg_d = (h_nxt >= BG_BEG) && (h_nxt < BG_END) && !vs_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_out_n <= 1'b0;
      vsync_out_n <= 1'b0;
      blank       <= 1'b1;
      burst_gate  <= 1'b0;
      sync_oe     <= 1'b0;
      pal_colour  <= 1'b0;
    end else begin
      hsync_out_n <= ~hs_d;
      vsync_out_n <= ~vs_d;
      blank       <= bl_d;
      burst_gate  <= bg_d;
      sync_oe     <= sel_master;
      pal_colour  <= sel_pal;
    end
  end

endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen
  import vs_pkg::*;
#(
  parameter int CLK_LINE_525 = 858,
  parameter int CLK_LINE_625 = 864,
  parameter int LINES_525    = 525,
  parameter int LINES_625    = 625,
  parameter int HSYNC_W      = 64,
  parameter int ACTIVE_START = 122,
  parameter int FRONT_PORCH  = 16,
  parameter int BURST_DELAY  = 8,
  parameter int BURST_LEN    = 34,
  parameter int VSYNC_HL     = 6,
  parameter int VBLANK_HL    = 40,
  localparam int HW = $clog2((CLK_LINE_525 > CLK_LINE_625) ? CLK_LINE_525 : CLK_LINE_625),
  localparam int VW = $clog2(((LINES_525 > LINES_625) ? LINES_525 : LINES_625) + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          sel_pal,
  input  logic          sel_pal60,
  input  logic          sel_master,
  input  logic          sel_interlace,
  input  logic          sel_long_field,
  input  logic          hsync_in_n,
  input  logic          vsync_in_n,
  output logic          hsync_out_n,
  output logic          vsync_out_n,
  output logic          sync_oe,
  output logic          pix_clk,
  output logic          blank,
  output logic          burst_gate,
  output logic          pal_colour,
  output logic          field,
  output logic [HW-1:0] h_count,
  output logic [VW-1:0] half_line
);

  logic          std_625;
  logic [HW-1:0] line_len;
  logic [VW-1:0] field_len;
  scan_e         scan;
  logic [HW-1:0] h_nxt;
  logic [VW-1:0] vh_nxt;
  logic          line_start, mid_line;

  always_comb begin
    std_625   = sel_pal & ~sel_pal60;
    line_len  = std_625 ? HW'(CLK_LINE_625) : HW'(CLK_LINE_525);
    scan      = sel_interlace  ? SCAN_INTER :
                sel_long_field ? SCAN_LONG  : SCAN_SHORT;
    field_len = VW'(field_half_lines(std_625 ? LINES_625 : LINES_525, scan));
  end

  vs_line_timer #(.HW(HW)) u_line (
    .clk        (clk),
    .rst        (rst),
    .pix_en     (pix_en),
    .slave      (~sel_master),
    .hsync_in_n (hsync_in_n),
    .line_len   (line_len),
    .h_cur      (h_count),
    .h_nxt      (h_nxt),
    .line_start (line_start),
    .mid_line   (mid_line),
    .pix_clk    (pix_clk)
  );

  vs_field_timer #(.VW(VW)) u_field (
    .clk        (clk),
    .rst        (rst),
    .pix_en     (pix_en),
    .slave      (~sel_master),
    .vsync_in_n (vsync_in_n),
    .line_start (line_start),
    .mid_line   (mid_line),
    .interlace  (sel_interlace),
    .field_len  (field_len),
    .vh_cur     (half_line),
    .vh_nxt     (vh_nxt),
    .field      (field)
  );

  vs_decode #(
    .HW(HW), .VW(VW), .HSYNC_W(HSYNC_W), .ACTIVE_START(ACTIVE_START),
    .FRONT_PORCH(FRONT_PORCH), .BURST_DELAY(BURST_DELAY), .BURST_LEN(BURST_LEN),
    .VSYNC_HL(VSYNC_HL), .VBLANK_HL(VBLANK_HL)
  ) u_dec (
    .clk         (clk),
    .rst         (rst),
    .h_nxt       (h_nxt),
    .vh_nxt      (vh_nxt),
    .line_len    (line_len),
    .sel_master  (sel_master),
    .sel_pal     (sel_pal),
    .hsync_out_n (hsync_out_n),
    .vsync_out_n (vsync_out_n),
    .blank       (blank),
    .burst_gate  (burst_gate),
    .sync_oe     (sync_oe),
    .pal_colour  (pal_colour)
  );

endmodule

// File: rtl/vs_sync_checker.sv
module vs_sync_checker #(
  parameter int HW = 10,
  parameter int VW = 10,
  parameter int LEN_A = 858,
  parameter int LEN_B = 864
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic          sel_pal,
  input logic          sel_pal60,
  input logic          sel_master,
  input logic          hsync_in_n,
  input logic          hsync_out_n,
  input logic          sync_oe,
  input logic          pix_clk,
  input logic          blank,
  input logic          burst_gate,
  input logic          pal_colour,
  input logic          field,
  input logic [HW-1:0] h_count,
  input logic [VW-1:0] half_line
);

  logic [HW-1:0] exp_last;
  assign exp_last = (sel_pal && !sel_pal60) ? HW'(LEN_B - 1) : HW'(LEN_A - 1);

  p_line_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (pix_en && sel_master && h_count == exp_last) |=> (h_count == '0));

  p_hsync_start_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_out_n) |-> (h_count == '0));

  p_oe_follow_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sync_oe == $past(sel_master)));

  p_burst_in_blank_r5: assert property (@(posedge clk) disable iff (rst)
    burst_gate |-> blank);

  p_pixclk_r6: assert property (@(posedge clk) disable iff (rst)
    pix_en |=> ((h_count == '0) ? pix_clk : (pix_clk != $past(pix_clk))));

  p_slave_lock_r7: assert property (@(posedge clk) disable iff (rst)
    (pix_en && $past(pix_en) && !sel_master && $past(hsync_in_n) && !hsync_in_n)
      |=> (h_count == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(h_count) && $stable(half_line) && $stable(field) && $stable(pix_clk)));

  p_colour_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pal_colour == $past(sel_pal)));

endmodule

bind vid_sync_gen vs_sync_checker #(
  .HW(HW), .VW(VW), .LEN_A(CLK_LINE_525), .LEN_B(CLK_LINE_625)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pix_en      (pix_en),
  .sel_pal     (sel_pal),
  .sel_pal60   (sel_pal60),
  .sel_master  (sel_master),
  .hsync_in_n  (hsync_in_n),
  .hsync_out_n (hsync_out_n),
  .sync_oe     (sync_oe),
  .pix_clk     (pix_clk),
  .blank       (blank),
  .burst_gate  (burst_gate),
  .pal_colour  (pal_colour),
  .field       (field),
  .h_count     (h_count),
  .half_line   (half_line)
);

// File: tb/vid_sync_gen_bench.sv
module vid_sync_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LA = 20, LB = 24, NA = 9, NB = 11;
  localparam int HS = 3, ACT = 8, FP = 2, BD = 1, BL = 2, VS = 2, VB = 4;
  localparam int HW = $clog2(LB);
  localparam int VW = $clog2(NB + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0;
  logic sel_pal = 1'b0, sel_pal60 = 1'b0, sel_master = 1'b1;
  logic sel_interlace = 1'b0, sel_long_field = 1'b0;
  logic hsync_in_n = 1'b1, vsync_in_n = 1'b1;
  logic hsync_out_n, vsync_out_n, sync_oe, pix_clk, blank, burst_gate, pal_colour, field;
  logic [HW-1:0] h_count;
  logic [VW-1:0] half_line;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_sync_gen #(
    .CLK_LINE_525(LA), .CLK_LINE_625(LB), .LINES_525(NA), .LINES_625(NB),
    .HSYNC_W(HS), .ACTIVE_START(ACT), .FRONT_PORCH(FP), .BURST_DELAY(BD),
    .BURST_LEN(BL), .VSYNC_HL(VS), .VBLANK_HL(VB)
  ) u_vid_sync_gen (
    .clk(clk), .rst(rst), .pix_en(pix_en), .sel_pal(sel_pal), .sel_pal60(sel_pal60),
    .sel_master(sel_master), .sel_interlace(sel_interlace), .sel_long_field(sel_long_field),
    .hsync_in_n(hsync_in_n), .vsync_in_n(vsync_in_n), .hsync_out_n(hsync_out_n),
    .vsync_out_n(vsync_out_n), .sync_oe(sync_oe), .pix_clk(pix_clk), .blank(blank),
    .burst_gate(burst_gate), .pal_colour(pal_colour), .field(field),
    .h_count(h_count), .half_line(half_line)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply_reset();
    rst = 1'b1;
    pix_en = 1'b0;
    step();
    step();
    // R10: reset state
    check("R10 h_count", int'(h_count), 0);
    check("R10 half_line", int'(half_line), 0);
    check("R10 field", int'(field), 0);
    check("R10 hsync_out_n", int'(hsync_out_n), 0);
    check("R10 vsync_out_n", int'(vsync_out_n), 0);
    check("R10 blank", int'(blank), 1);
    check("R10 burst_gate", int'(burst_gate), 0);
    check("R10 pix_clk", int'(pix_clk), 1);
    check("R10 sync_oe", int'(sync_oe), 0);
    check("R10 pal_colour", int'(pal_colour), 0);
    rst = 1'b0;
  endtask

  task automatic run_master(input bit pal, input bit p60, input bit il, input bit lg, input bit gap);
    int len, lines, fl, j, total, cyc;
    bit en_last;
    sel_pal = pal; sel_pal60 = p60; sel_interlace = il; sel_long_field = lg;
    sel_master = 1'b1; hsync_in_n = 1'b1; vsync_in_n = 1'b1;
    apply_reset();
    len   = (pal && !p60) ? LB : LA;
    lines = (pal && !p60) ? NB : NA;
    fl    = il ? lines : (lg ? lines + 1 : lines - 1);
    total = 2 * fl * (len / 2) + len;
    j = 0;
    cyc = 0;
    pix_en = 1'b1;
    while (j < total) begin
      int h, hl, vh, fld;
      en_last = pix_en;
      step();
      if (en_last) j++;
      cyc++;
      h   = j % len;
      hl  = j / (len / 2);
      vh  = hl % fl;
      fld = il ? ((hl / fl) % 2) : 0;
      check(en_last ? "R1 h_count" : "R9 h_count held", int'(h_count), h);
      check(en_last ? "R2 half_line" : "R9 half_line held", int'(half_line), vh);
      check("R2 field", int'(field), fld);
      check("R3 hsync_out_n", int'(hsync_out_n), (h < HS) ? 0 : 1);
      check("R3 vsync_out_n", int'(vsync_out_n), (vh < VS) ? 0 : 1);
      check("R4 blank", int'(blank), (h < ACT || h >= len - FP || vh < VB) ? 1 : 0);
      check("R5 burst_gate", int'(burst_gate),
            (h >= HS + BD && h < HS + BD + BL && vh >= VS) ? 1 : 0);
      check(en_last ? "R6 pix_clk" : "R9 pix_clk held", int'(pix_clk), (h % 2 == 0) ? 1 : 0);
      check("R3 sync_oe", int'(sync_oe), 1);
      check("R11 pal_colour", int'(pal_colour), int'(pal));
      pix_en = gap ? ((cyc % 3) != 2) : 1'b1;
    end
  endtask

  // One slave line of 'per' cycles; vsync falls at cycle vs_at (-1 = none).
  task automatic slave_line(input int per, input int vs_at, input int exp_hl_start);
    for (int c = 0; c < per; c++) begin
      if (c == 0) hsync_in_n = 1'b0;
      if (c == 2) hsync_in_n = 1'b1;
      if (c == vs_at) vsync_in_n = 1'b0;
      if (vs_at >= 0 && c == vs_at + 2) vsync_in_n = 1'b1;
      step();
      check("R7 slave h_count", int'(h_count), c);
      check("R6 slave pix_clk", int'(pix_clk), (c % 2 == 0) ? 1 : 0);
      if (c == 0 && exp_hl_start >= 0)
        check("R8 half_line at line start", int'(half_line), exp_hl_start);
      if (c == vs_at) begin
        check("R8 half_line after vsync", int'(half_line), 0);
        check("R8 field after vsync", int'(field), (vs_at == 0) ? 0 : 1);
      end
    end
  endtask

  task automatic run_slave();
    sel_pal = 1'b0; sel_pal60 = 1'b0; sel_interlace = 1'b1; sel_long_field = 1'b0;
    sel_master = 1'b0; hsync_in_n = 1'b1; vsync_in_n = 1'b1;
    apply_reset();
    pix_en = 1'b1;
    step();
    check("R3 sync_oe slave", int'(sync_oe), 0);
    slave_line(16, -1, -1);
    slave_line(16, -1, -1);
    slave_line(16, 0, 0);
    slave_line(16, -1, 2);
    slave_line(16, 5, -1);
    check("R8 field kept", int'(field), 1);
    slave_line(16, -1, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int k = 0; k < 32; k++)
      run_master(k[0], k[1], k[2], k[3], k[4]);
    run_slave();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule